// File: doc/BRIEF.md
# Two-slot alternating receive frame buffer

The block takes incoming frames as a byte stream (a byte strobe, the byte, and a flag on the final byte). It stores each frame in one of two packet slots, and a 32-bit register bus reads the stored frames back. The receiver fills the slots strictly in turn: slot 0, slot 1, slot 0, and so on. When a frame is complete, the receiver hands the slot over to software by setting that slot's done flag. Software polls the slots in the same order. It reads the frame words, then writes the slot's status register with done at zero, which gives the slot back to the receiver.

If the slot whose turn it is still belongs to software when a new frame begins, the whole frame is discarded and a drop counter advances. The turn does not move, so ordering is preserved. A frame longer than a slot is cut to the slot's capacity and still completes. An interrupt line pulses once for every completed frame whose slot has its interrupt enabled.

The receive engine is a three-state machine:
- `ST_IDLE` waits for the first byte of a frame.
- `ST_FILL` writes bytes into the chosen slot.
- `ST_DISCARD` swallows a dropped frame.

The transitions are:
- `ST_IDLE` goes to `ST_FILL` on a first byte that is not final when the slot in turn is free.
- `ST_IDLE` goes to `ST_DISCARD` on a first byte that is not final when that slot is owned by software.
- `ST_IDLE` stays in `ST_IDLE` for a one-byte frame, whether it is stored or dropped.
- `ST_FILL` goes to `ST_IDLE` on the final byte.
- `ST_DISCARD` goes to `ST_IDLE` on the final byte.

Top module: `rxpp_buffer`

## Requirements
- R1: After reset both done flags and both interrupt enables are 0, `irq` is low, `drop_cnt` is 0, and both status registers read 0.
- R2: Address decoding is as follows.
  - A bus address with bit 12 set selects the buffer. Slot 0 spans 0x1000-0x17FF and slot 1 spans 0x1800-0x1FFF.
  - Each slot's status word sits at slot base + 0x7FC. Bit 0 of the status word is done, bit 3 is interrupt enable, and all other bits read 0.
  - Any address with bit 12 clear reads 0.
  - `bus_rdata` shows the addressed word in the cycle after `bus_rd` is sampled.
- R3: Byte n of a frame is stored big-endian. It lands in word n/4 of its slot (byte address slot base + 4*(n/4)), in bits [31-8*(n mod 4) -: 8]. Lanes of the final word past the frame's end read 0.
- R4: Stored frames go to slot 0, slot 1, slot 0, ... in strict alternation. A dropped frame does not advance the turn.
- R5: A stored frame's done flag reads 1 after the clock edge that samples its final byte.
- R6: A status write with bit 0 = 0 clears done. A status write with bit 0 = 1 never sets done. Bit 3 of every status write loads the interrupt enable.
- R7: If the slot in turn has done = 1 when a frame's first byte is sampled, the whole frame is discarded and `drop_cnt` rises by exactly 1 (wrapping). The slot's contents and status are left as they were.
- R8: The drop decision uses the done value held before the edge. A release write to the slot in turn, sampled in the same cycle as a first byte, clears done but the frame is still dropped.
- R9: A frame longer than 2044 bytes keeps its first 2044 bytes, ignores the rest, and still sets done when its final byte arrives.
- R10: `irq` is high for exactly the one cycle in which a slot's done first reads 1. It pulses only if that slot's interrupt enable was 1 before the completing edge.
- R11: A status write to a slot in the same cycle as the final byte of a frame into that slot leaves done = 1. The written enable bit still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte on `rx_data` is the frame's final byte |
| bus_addr | input | 13 | Byte address of the register bus access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | One-cycle frame-complete interrupt |
| drop_cnt | output | 16 | Number of discarded frames, wrapping |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both.

The first pair is a software release and the receiver's slot decision. The bench drives a status write that clears done on the slot in turn in the very cycle the next frame's first byte arrives. It then expects the frame to be dropped, the drop count to rise, and the status to read done = 0.

The second pair is a status write and the completion of a frame into the same slot. The bench lines up a write of zero with the final byte and expects done to stay set, the enable to clear, and the interrupt to fire from the enable value held before that edge.

A behavioural model is compared against `irq`, `drop_cnt` and every read on every clock.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

    // Receive engine states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FILL    = 2'd1,
        ST_DISCARD = 2'd2
    } rx_state_e;

    localparam int BUS_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int SLOTS    = 2;
    localparam int DONE_BIT = 0;   // status bit software reads for completion
    localparam int IE_BIT   = 3;   // status bit enabling the interrupt

endpackage

// File: rtl/rxpp_fill_fsm.sv
module rxpp_fill_fsm
    import rxpp_pkg::*;
#(
    parameter int SLOT_AW = 9,
    parameter int CNT_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_data,
    input  logic                 rx_last,
    input  logic [SLOTS-1:0]     slot_done,
    output logic                 wr_en,
    output logic [SLOT_AW:0]     wr_addr,
    output logic [BUS_W-1:0]     wr_data,
    output logic                 fin_en,
    output logic                 fin_slot,
    output logic [CNT_W-1:0]     drop_cnt
);

    rx_state_e state_q, state_d;

    logic               turn_q;      // slot whose turn is next (R4)
    logic               slot_q;      // slot of the frame in flight
    logic [SLOT_AW-1:0] widx_q;      // next word index inside the slot
    logic [1:0]         lane_q;      // next byte lane inside the word
    logic [BUS_W-1:0]   wbuf_q;      // partially assembled word
    logic [CNT_W-1:0]   drop_q;

    logic               starting, owned, take, room, store, drop_pulse;
    logic               cur_slot;
    logic [SLOT_AW-1:0] cur_widx;
    logic [1:0]         cur_lane;
    logic [BUS_W-1:0]   merged;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_valid && !rx_last)
                    state_d = owned ? ST_DISCARD : ST_FILL;   // R7 decision
            end
            ST_FILL: begin
                if (rx_valid && rx_last) state_d = ST_IDLE;
            end
            ST_DISCARD: begin
                if (rx_valid && rx_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        starting   = (state_q == ST_IDLE) && rx_valid;
        // R8: the registered done flag decides, whatever software writes now
        owned      = slot_done[turn_q];
        take       = rx_valid && ((state_q == ST_FILL) ||
                                  ((state_q == ST_IDLE) && !owned));
        cur_slot   = (state_q == ST_IDLE) ? turn_q : slot_q;
        cur_widx   = (state_q == ST_IDLE) ? '0 : widx_q;
        cur_lane   = (state_q == ST_IDLE) ? 2'd0 : lane_q;
        room       = ~&cur_widx;                 // R9: last word index is status
        store      = take && room;
        drop_pulse = starting && owned;

        // R3: big-endian packing, fresh words start cleared
        merged = (cur_lane == 2'd0) ? '0 : wbuf_q;
        unique case (cur_lane)
            2'd0:    merged[31:24] = rx_data;
            2'd1:    merged[23:16] = rx_data;
            2'd2:    merged[15:8]  = rx_data;
            default: merged[7:0]   = rx_data;
        endcase

        wr_en    = store && ((cur_lane == 2'd3) || rx_last);
        wr_addr  = {cur_slot, cur_widx};
        wr_data  = merged;
        fin_en   = take && rx_last;              // R5 / R9
        fin_slot = cur_slot;
        drop_cnt = drop_q;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            turn_q <= 1'b0;
            slot_q <= 1'b0;
            widx_q <= '0;
            lane_q <= 2'd0;
            wbuf_q <= '0;
            drop_q <= '0;
        end else begin
            if (fin_en)
                turn_q <= ~turn_q;               // R4: only stored frames advance
            if (starting && !owned)
                slot_q <= turn_q;
            if (store) begin
                wbuf_q <= merged;
                if (cur_lane == 2'd3) begin
                    lane_q <= 2'd0;
                    widx_q <= cur_widx + 1'b1;
                end else begin
                    lane_q <= cur_lane + 2'd1;
                    widx_q <= cur_widx;
                end
            end else if (starting) begin
                lane_q <= 2'd0;
                widx_q <= '0;
            end
            if (drop_pulse)
                drop_q <= drop_q + 1'b1;         // R7
        end
    end

endmodule

// File: rtl/rxpp_slot_ctrl.sv
module rxpp_slot_ctrl
    import rxpp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_slot,
    input  logic             wr_done_bit,
    input  logic             wr_ie_bit,
    input  logic             fin_en,
    input  logic             fin_slot,
    output logic [SLOTS-1:0] slot_done,
    output logic [SLOTS-1:0] slot_ie,
    output logic             irq
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic done_q, ie_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                done_q <= 1'b0;
                ie_q   <= 1'b0;
            end else begin
                if (reg_wr && (reg_slot == 1'(s))) begin
                    ie_q <= wr_ie_bit;                   // R6
                    if (!wr_done_bit) done_q <= 1'b0;    // R6: clear only
                end
                if (fin_en && (fin_slot == 1'(s)))
                    done_q <= 1'b1;                      // R11: hardware set wins
            end
        end

        assign slot_done[s] = done_q;
        assign slot_ie[s]   = ie_q;
    end

    // R10: pulse from the enable held before the completing edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fin_en && slot_ie[fin_slot];
    end

endmodule

// File: rtl/rxpp_store.sv
module rxpp_store
    import rxpp_pkg::*;
#(
    parameter int SLOT_AW = 9
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [SLOT_AW:0]   wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               rd_en,
    input  logic [SLOT_AW:0]   rd_addr,
    output logic [BUS_W-1:0]   rd_word
);

    localparam int DEPTH = 1 << (SLOT_AW + 1);

    logic [BUS_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_word <= mem[rd_addr];
    end

endmodule

// File: rtl/rxpp_buffer.sv
module rxpp_buffer
    import rxpp_pkg::*;
#(
    parameter int  SLOT_AW = 9,
    parameter int  CNT_W   = 16,
    localparam int ADDR_W  = SLOT_AW + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_data,
    input  logic               rx_last,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic               bus_rd,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               irq,
    output logic [CNT_W-1:0]   drop_cnt
);

    logic [SLOTS-1:0]   slot_done, slot_ie;
    logic               fin_en, fin_slot, wr_en;
    logic [SLOT_AW:0]   wr_addr;
    logic [BUS_W-1:0]   wr_data, mem_word, stat_w, stat_q;
    logic               in_region, a_slot, is_stat, reg_wr, rd_mem, rsel_q;
    logic [SLOT_AW-1:0] a_word;
    logic               unused_bits;

    // R2: address decode
    assign in_region = bus_addr[ADDR_W-1];
    assign a_slot    = bus_addr[ADDR_W-2];
    assign a_word    = bus_addr[ADDR_W-3:2];
    assign is_stat   = &a_word;
    assign reg_wr    = bus_wr && in_region && is_stat;
    assign rd_mem    = bus_rd && in_region && !is_stat;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:IE_BIT+1],
                           bus_wdata[IE_BIT-1:DONE_BIT+1]};

    always_comb begin
        stat_w = '0;
        if (in_region && is_stat) begin
            stat_w[DONE_BIT] = slot_done[a_slot];
            stat_w[IE_BIT]   = slot_ie[a_slot];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsel_q <= 1'b0;
            stat_q <= '0;
        end else if (bus_rd) begin
            rsel_q <= rd_mem;
            stat_q <= stat_w;
        end
    end

    assign bus_rdata = rsel_q ? mem_word : stat_q;

    rxpp_fill_fsm #(.SLOT_AW(SLOT_AW), .CNT_W(CNT_W)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_last  (rx_last),
        .slot_done(slot_done),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fin_en   (fin_en),
        .fin_slot (fin_slot),
        .drop_cnt (drop_cnt)
    );

    rxpp_slot_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_slot   (a_slot),
        .wr_done_bit(bus_wdata[DONE_BIT]),
        .wr_ie_bit  (bus_wdata[IE_BIT]),
        .fin_en     (fin_en),
        .fin_slot   (fin_slot),
        .slot_done  (slot_done),
        .slot_ie    (slot_ie),
        .irq        (irq)
    );

    rxpp_store #(.SLOT_AW(SLOT_AW)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_en  (rd_mem),
        .rd_addr({a_slot, a_word}),
        .rd_word(mem_word)
    );

endmodule

// File: rtl/rxpp_buffer_chk.sv
module rxpp_buffer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [1:0]       slot_done,
    input logic             fin_en,
    input logic             fin_slot,
    input logic             wr_en,
    input logic             wr_slot,
    input logic [CNT_W-1:0] drop_cnt
);

    logic exp_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      exp_slot <= 1'b0;
        else if (fin_en) exp_slot <= ~exp_slot;
    end

    // R10: an interrupt always coincides with a slot handed to software
    p_irq_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (slot_done != 2'b00));

    // R5: done only rises after a completion into that slot
    p_done_rise_s0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_done[0]) |-> $past(fin_en && !fin_slot));

    p_done_rise_s1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_done[1]) |-> $past(fin_en && fin_slot));

    // R7: the drop count moves by one at a time
    p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == CNT_W'($past(drop_cnt) + 1'b1)));

    // R7: storage never touches a slot owned by software
    p_no_write_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !slot_done[wr_slot]);

    // R4: completions alternate between the slots
    p_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fin_en |-> (fin_slot == exp_slot));

endmodule

bind rxpp_buffer rxpp_buffer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .slot_done(slot_done),
    .fin_en   (fin_en),
    .fin_slot (fin_slot),
    .wr_en    (wr_en),
    .wr_slot  (wr_addr[SLOT_AW]),
    .drop_cnt (drop_cnt)
);

// File: tb/test_rxpp_buffer.sv
module test_rxpp_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 2044;
    localparam logic [12:0] S0   = 13'h1000;
    localparam logic [12:0] S1   = 13'h1800;
    localparam logic [12:0] S0ST = 13'h17FC;
    localparam logic [12:0] S1ST = 13'h1FFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_last = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [15:0] drop_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxpp_buffer i_rxpp_buffer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq(irq), .drop_cnt(drop_cnt)
    );

    int    n_chk = 0, n_fail = 0, irq_seen = 0;
    bit    finished = 0;
    string rd_tag = "";

    // ---------------- behavioural reference model ----------------
    int          mb [2][2048];
    bit [1:0]    m_done, m_ie;
    bit          m_turn, m_busy, m_take, m_slot, m_irq, m_rdv;
    int          m_cnt, m_drop;
    logic [31:0] m_rexp;
    string       m_rtag;

    function automatic logic [31:0] exp_read(logic [12:0] a);
        int s, w;
        if (!a[12]) return 32'h0;
        s = int'(a[11]);
        w = int'(a[10:2]);
        if (w == 511) return {28'd0, m_ie[s], 2'b00, m_done[s]};
        return {8'(mb[s][4*w]), 8'(mb[s][4*w+1]), 8'(mb[s][4*w+2]), 8'(mb[s][4*w+3])};
    endfunction

    always @(posedge clk) begin
        bit       irq_n, s;
        bit [1:0] own_pre, ie_pre;
        if (!rst_n) begin
            m_done = 0; m_ie = 0; m_turn = 0; m_busy = 0; m_take = 0;
            m_slot = 0; m_irq = 0; m_rdv = 0; m_cnt = 0; m_drop = 0;
        end else begin
            irq_n   = 0;
            own_pre = m_done;
            ie_pre  = m_ie;
            m_rdv   = bus_rd;
            if (bus_rd) begin
                m_rexp = exp_read(bus_addr);
                m_rtag = rd_tag;
            end
            if (bus_wr && bus_addr[12] && (bus_addr[10:2] == 9'h1FF)) begin
                s = bus_addr[11];
                m_ie[s] = bus_wdata[3];
                if (!bus_wdata[0]) m_done[s] = 0;
            end
            if (rx_valid) begin
                if (!m_busy) begin
                    m_busy = 1;
                    if (own_pre[m_turn]) begin
                        m_take = 0;
                        m_drop = (m_drop + 1) & 16'hFFFF;
                    end else begin
                        m_take = 1;
                        m_slot = m_turn;
                        m_cnt  = 0;
                    end
                end
                if (m_take && m_cnt < CAP) begin
                    if (m_cnt % 4 == 0)
                        for (int k = 1; k < 4; k++) mb[m_slot][m_cnt+k] = 0;
                    mb[m_slot][m_cnt] = int'(rx_data);
                    m_cnt++;
                end
                if (rx_last) begin
                    m_busy = 0;
                    if (m_take) begin
                        m_done[m_slot] = 1;
                        irq_n  = ie_pre[m_slot];
                        m_turn = ~m_turn;
                    end
                end
            end
            m_irq = irq_n;
        end
    end

    always @(posedge clk) if (rst_n && irq) irq_seen++;

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10 irq per cycle", {31'd0, irq}, {31'd0, m_irq});
            chk("R7 drop_cnt per cycle", {16'd0, drop_cnt}, m_drop);
            if (m_rdv) chk(m_rtag, bus_rdata, m_rexp);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [7:0] pat(int seed, int i);
        return 8'(seed * 7 + i * 13 + 1);
    endfunction

    function automatic logic [31:0] wexp(int seed, int b0, int n);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++)
            if (b0 + k < n) w[31-8*k -: 8] = pat(seed, b0 + k);
        return w;
    endfunction

    task automatic drive(bit v, logic [7:0] d, bit l, bit w, bit r,
                         logic [12:0] a, logic [31:0] wd, string tag);
        @(negedge clk);
        rx_valid = v; rx_data = d; rx_last = l;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = wd; rd_tag = tag;
    endtask

    task automatic idle();
        drive(0, 8'h0, 0, 0, 0, 13'h0, 32'h0, "");
    endtask

    task automatic wr(logic [12:0] a, logic [31:0] d);
        drive(0, 8'h0, 0, 1, 0, a, d, "");
    endtask

    task automatic rd_lit(logic [12:0] a, logic [31:0] exp, string tag);
        drive(0, 8'h0, 0, 0, 1, a, 32'h0, tag);
        idle();
        chk(tag, bus_rdata, exp);
    endtask

    task automatic frame(int seed, int len);
        for (int i = 0; i < len; i++)
            drive(1, pat(seed, i), i == len - 1, 0, 0, 13'h0, 32'h0, "");
        idle();
    endtask

    // ---------------- scenario ----------------
    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 drop_cnt after reset", {16'd0, drop_cnt}, 32'd0);
        rd_lit(S0ST, 32'h0, "R1 slot0 status");
        rd_lit(S1ST, 32'h0, "R1 slot1 status");
        rd_lit(13'h0FFC, 32'h0, "R2 outside region");

        wr(S0ST, 32'h8);
        wr(S1ST, 32'h8);
        rd_lit(S0ST, 32'h8, "R6 enable written");

        base = irq_seen;
        frame(1, 10);
        idle();
        chk("R10 one pulse", irq_seen - base, 1);
        rd_lit(S0ST, 32'h9, "R5 slot0 done");
        rd_lit(S0, wexp(1, 0, 10), "R3 word0");
        rd_lit(S0 + 13'h4, wexp(1, 4, 10), "R3 word1");
        rd_lit(S0 + 13'h8, wexp(1, 8, 10), "R3 padded word");

        frame(2, 5);
        rd_lit(S1ST, 32'h9, "R4 second frame in slot1");
        rd_lit(S1 + 13'h4, wexp(2, 4, 5), "R3 slot1 tail");

        frame(3, 6);
        chk("R7 dropped frame counted", {16'd0, drop_cnt}, 32'd1);
        rd_lit(S0, wexp(1, 0, 10), "R7 slot0 contents kept");
        rd_lit(S0ST, 32'h9, "R7 slot0 status kept");

        wr(S0ST, 32'h8);
        rd_lit(S0ST, 32'h8, "R6 done cleared");
        wr(S0ST, 32'h9);
        rd_lit(S0ST, 32'h8, "R6 set ignored");

        frame(4, 1);
        rd_lit(S0, wexp(4, 0, 1), "R4 turn kept after drop");
        rd_lit(S0ST, 32'h9, "R5 one-byte frame done");

        // R8: release of slot1 in the same cycle as a first byte
        drive(1, pat(5, 0), 0, 1, 0, S1ST, 32'h8, "");
        for (int i = 1; i < 4; i++)
            drive(1, pat(5, i), i == 3, 0, 0, 13'h0, 32'h0, "");
        idle();
        chk("R8 same-cycle release still drops", {16'd0, drop_cnt}, 32'd2);
        rd_lit(S1ST, 32'h8, "R8 slot1 released");

        // R11: status write coincides with the final byte
        base = irq_seen;
        for (int i = 0; i < 3; i++)
            drive(1, pat(6, i), 0, 0, 0, 13'h0, 32'h0, "");
        drive(1, pat(6, 3), 1, 1, 0, S1ST, 32'h0, "");
        idle();
        idle();
        chk("R11 irq from old enable", irq_seen - base, 1);
        rd_lit(S1ST, 32'h1, "R11 done kept, enable cleared");
        rd_lit(S1, wexp(6, 0, 4), "R11 slot1 data");

        // R10: no pulse when the enable is clear
        wr(S0ST, 32'h8);
        frame(7, 3);
        wr(S1ST, 32'h0);
        base = irq_seen;
        frame(8, 7);
        idle();
        chk("R10 no pulse with enable clear", irq_seen - base, 0);
        rd_lit(S1ST, 32'h1, "R5 slot1 done");

        // R9: oversize frame
        wr(S0ST, 32'h8);
        frame(9, 2050);
        rd_lit(S0ST, 32'h9, "R9 done after truncation");
        rd_lit(S0 + 13'h7F8, wexp(9, 2040, 2044), "R9 last kept word");
        rd_lit(S0, wexp(9, 0, 2044), "R9 first word");

        repeat (3) idle();
        finish_run();
    end

endmodule